// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one memory burst, one per clock. A read or write column command pulses the start strobe together with a start column. From the next cycle the block puts out the start column, then the rest of the burst. Each address comes with a valid flag, and a last-beat flag marks the final address of a fixed-length burst.

The burst length code and the sequence type are sampled once, on the start strobe, and hold for the whole burst. Fixed-length bursts stay inside the aligned block of the burst length that holds the start column, and wrap within that block. The order inside the block is either linear or interleaved (an XOR with the beat count). A full-page burst walks the whole 256-column page in linear order. It runs until a stop input or a new start ends it.

A start strobe may arrive on any cycle, including in the middle of a burst. The remaining addresses are dropped and a fresh burst of the full programmed length begins from the new column.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `valid_o` and `last_o` are low.
- R2: On the cycle after `start_i` is sampled high at a rising clock edge, `valid_o` is high and `col_o` equals the `start_col_i` sampled with that strobe.
- R3: `burst_len_i` selects the number of valid beats: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. Codes 4, 5 and 6 give 1 beat. A fixed-length burst does not end before its last beat.
- R4: With `interleave_i` = 0, beat k (counting from 0) of a fixed-length burst of length L has low bits equal to (start low bits + k) mod L.
- R5: With `interleave_i` = 1, beat k of a fixed-length burst has low bits equal to start low bits XOR k. For example, length 8 from column 2 gives 2, 3, 0, 1, 6, 7, 4, 5.
- R6: Every address of a fixed-length burst keeps the column bits above log2(L) equal to those of the start column.
- R7: `last_o` is high only on the final beat of a fixed-length burst. `valid_o` is low on the cycle after that beat unless `start_i` was high at that edge.
- R8: A full-page burst always uses linear order, whatever `interleave_i` is. It wraps from column 255 to column 0, never raises `last_o`, and stays valid until it is stopped or restarted.
- R9: `stop_i` high at an edge without `start_i` makes `valid_o` low on the next cycle. When `start_i` is high at the same edge, the start wins.
- R10: A start strobe during a burst drops the remaining beats and begins a new burst of the full new length from the new column.
- R11: Changes to `burst_len_i` and `interleave_i` after the start strobe have no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Column command strobe; starts or restarts a burst |
| start_col_i | input | 8 | Start column sampled with the strobe |
| burst_len_i | input | 3 | Burst length code (see R3) |
| interleave_i | input | 1 | 1 = interleaved order, 0 = linear order |
| stop_i | input | 1 | Ends the current burst |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | `col_o` holds a beat of a burst |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bound checker watches, on every cycle: the first beat after a strobe, that no address leaves its aligned block, the one-step advance in linear order, the drop of valid after a last beat or a stop, that no burst ends early, and that a full-page burst never flags a last beat. Only the bench scenarios can show the exact interleaved orders and the beat counts for each length code, including the unsupported codes. The same holds for the page wrap from 255 to 0, the outcome of a restart in the middle of a burst, and the fact that configuration changes during a burst are ignored.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
// Package bcg_pkg
// Shared encodings of the burst column address generator.
// Assumes the burst length code is 3 bits wide.
package bcg_pkg;

    // Burst length codes seen on burst_len_i
    localparam logic [2:0] LEN_CODE_1    = 3'd0;
    localparam logic [2:0] LEN_CODE_2    = 3'd1;
    localparam logic [2:0] LEN_CODE_4    = 3'd2;
    localparam logic [2:0] LEN_CODE_8    = 3'd3;
    localparam logic [2:0] LEN_CODE_PAGE = 3'd7;

    // Address ordering inside an aligned block
    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

endpackage

// File: rtl/bcg_len_decode.sv
`timescale 1ns/1ps
// Module bcg_len_decode
// Turns a burst length code into a block mask (burst length minus one)
// and a full-page flag. Unsupported codes decode as length 1.
// Assumes COL_W >= 3 so that length 8 fits inside the column.
module bcg_len_decode #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o
);
    import bcg_pkg::*;

    // Decode the length code into mask and full-page flag
    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        case (code_i)
            LEN_CODE_2:    mask_o = COL_W'(1);
            LEN_CODE_4:    mask_o = COL_W'(3);
            LEN_CODE_8:    mask_o = COL_W'(7);
            LEN_CODE_PAGE: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default:       mask_o = '0;
        endcase
    end
endmodule

// File: rtl/bcg_cfg_hold.sv
`timescale 1ns/1ps
// Module bcg_cfg_hold
// Captures start column, block mask, full-page flag and ordering on
// each start strobe and holds them for the whole burst.
// Assumes the decoded config is valid in the cycle of the strobe.
module bcg_cfg_hold #(
    parameter int COL_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [COL_W-1:0]    col_i,
    input  logic [COL_W-1:0]    mask_i,
    input  logic                full_i,
    input  bcg_pkg::order_e     order_i,
    output logic [COL_W-1:0]    col_o,
    output logic [COL_W-1:0]    mask_o,
    output logic                full_o,
    output bcg_pkg::order_e     order_o
);
    import bcg_pkg::*;

    // Register the burst configuration on a start strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_o   <= '0;
            mask_o  <= '0;
            full_o  <= 1'b0;
            order_o <= ORDER_LINEAR;
        end else if (load_i) begin
            col_o   <= col_i;
            mask_o  <= mask_i;
            full_o  <= full_i;
            // full page is linear whatever ordering was asked for
            order_o <= full_i ? ORDER_LINEAR : order_i;
        end
    end
endmodule

// File: rtl/bcg_beat_ctrl.sv
`timescale 1ns/1ps
// Module bcg_beat_ctrl
// Counts beats of the current burst and keeps the valid flag.
// A start restarts the count at zero; a stop or the final beat of a
// fixed-length burst clears valid. Start wins over stop.
// Assumes mask_i/full_i belong to the burst in progress.
module bcg_beat_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    output logic [COL_W-1:0] beat_o,
    output logic             valid_o,
    output logic             last_o
);
    logic at_end;

    // Final beat of a fixed-length burst
    always_comb at_end = valid_o && !full_i && (beat_o == mask_i);

    // Advance the beat counter and track whether a burst is running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_o  <= '0;
            valid_o <= 1'b0;
        end else if (start_i) begin
            beat_o  <= '0;
            valid_o <= 1'b1;
        end else if (valid_o) begin
            if (stop_i || at_end) begin
                valid_o <= 1'b0;
            end else begin
                beat_o <= beat_o + 1'b1;
            end
        end
    end

    assign last_o = at_end;
endmodule

// File: rtl/bcg_addr_form.sv
`timescale 1ns/1ps
// Module bcg_addr_form
// Forms the column address from the held start column and beat count:
// bits above the mask come from the start column, bits under the mask
// are start offset plus beat (linear) or start offset XOR beat.
// Purely combinational.
module bcg_addr_form #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  bcg_pkg::order_e  order_i,
    input  logic [COL_W-1:0] beat_i,
    output logic [COL_W-1:0] col_o
);
    import bcg_pkg::*;

    logic [COL_W-1:0] lin_off;
    logic [COL_W-1:0] xor_off;

    // Both candidate offsets inside the block
    always_comb begin
        lin_off = base_i + beat_i;
        xor_off = base_i ^ beat_i;
    end

    // Per-bit select: fixed upper bit or generated lower bit
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!mask_i[b])
                col_o[b] = base_i[b];
            else if (order_i == ORDER_XOR)
                col_o[b] = xor_off[b];
            else
                col_o[b] = lin_off[b];
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
`timescale 1ns/1ps
// Module burst_col_gen
// Top of the burst column address generator. A start strobe samples the
// start column, length code and ordering; from the next cycle one column
// address per clock is produced with valid and last-beat flags.
// Assumes synchronous active-low reset and COL_W >= 3.
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       burst_len_i,
    input  logic             interleave_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    import bcg_pkg::*;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic [COL_W-1:0] hold_col;
    logic [COL_W-1:0] hold_mask;
    logic             hold_full;
    order_e           hold_order;
    order_e           req_order;
    logic [COL_W-1:0] beat;

    // Map the ordering input onto the package enum
    always_comb req_order = interleave_i ? ORDER_XOR : ORDER_LINEAR;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (burst_len_i),
        .mask_o (dec_mask),
        .full_o (dec_full)
    );

    bcg_cfg_hold #(.COL_W(COL_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .col_i   (start_col_i),
        .mask_i  (dec_mask),
        .full_i  (dec_full),
        .order_i (req_order),
        .col_o   (hold_col),
        .mask_o  (hold_mask),
        .full_o  (hold_full),
        .order_o (hold_order)
    );

    bcg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .stop_i  (stop_i),
        .mask_i  (hold_mask),
        .full_i  (hold_full),
        .beat_o  (beat),
        .valid_o (valid_o),
        .last_o  (last_o)
    );

    bcg_addr_form #(.COL_W(COL_W)) u_addr (
        .base_i  (hold_col),
        .mask_i  (hold_mask),
        .order_i (hold_order),
        .beat_i  (beat),
        .col_o   (col_o)
    );
endmodule

// File: rtl/bcg_checker.sv
`timescale 1ns/1ps
// Module bcg_checker
// Cycle-by-cycle properties of burst_col_gen, seen from its ports.
// Keeps its own copy of the length code and ordering from each strobe.
module bcg_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       burst_len_i,
    input logic             interleave_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);
    logic [COL_W-1:0] ck_mask;
    logic             ck_full;
    logic             ck_ilv;

    // Own record of the burst shape, taken at each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_mask <= '0;
            ck_full <= 1'b0;
            ck_ilv  <= 1'b0;
        end else if (start_i) begin
            ck_ilv  <= interleave_i;
            ck_full <= (burst_len_i == 3'd7);
            case (burst_len_i)
                3'd1:    ck_mask <= COL_W'(1);
                3'd2:    ck_mask <= COL_W'(3);
                3'd3:    ck_mask <= COL_W'(7);
                3'd7:    ck_mask <= '1;
                default: ck_mask <= '0;
            endcase
        end
    end

    // R2: first beat carries the start column
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R3: a running burst does not end early
    a_r3_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i && !stop_i && !last_o) |=> valid_o);

    // R4: linear order steps by one inside the block
    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i && !stop_i && !last_o && (ck_full || !ck_ilv))
        |=> (((col_o - $past(col_o)) & ck_mask) == COL_W'(1)));

    // R6: upper bits stay fixed within a burst
    a_r6_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i)
        |=> (!valid_o || ((col_o ^ $past(col_o)) & ~ck_mask) == '0));

    // R7: last beat only while valid
    a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R7: valid drops after a last beat without a new strobe
    a_r7_last_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R8: full page never flags a last beat
    a_r8_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ck_full) |-> !last_o);

    // R9: stop ends the burst on the next cycle
    a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_bcg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .burst_len_i  (burst_len_i),
    .interleave_i (interleave_i),
    .stop_i       (stop_i),
    .col_o        (col_o),
    .valid_o      (valid_o),
    .last_o       (last_o)
);

// File: tb/burst_col_gen_test.sv
`timescale 1ns/1ps
// Directed bench for burst_col_gen: one task per scenario.
module burst_col_gen_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [7:0] start_col_i;
    logic [2:0] burst_len_i;
    logic       interleave_i;
    logic       stop_i;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    burst_col_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .burst_len_i(burst_len_i), .interleave_i(interleave_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 256;
            default: return 1;
        endcase
    endfunction

    // Expected column of beat k, from R4, R5, R6 and R8
    function automatic int exp_col(input int s, input logic [2:0] code, input bit ilv, input int k);
        int L, lo;
        L = len_of(code);
        if (code == 3'd7) return (s + k) % 256;
        lo = ilv ? ((s % L) ^ k) : (((s % L) + k) % L);
        return (s - (s % L)) + lo;
    endfunction

    task automatic launch(input int s, input logic [2:0] code, input bit ilv);
        @(negedge clk);
        start_i = 1; start_col_i = 8'(s); burst_len_i = code; interleave_i = ilv;
        @(negedge clk);
        start_i = 0;
    endtask

    // R2 R3 R4 R5 R6 R7: full burst, then valid low
    task automatic run_burst(input int s, input logic [2:0] code, input bit ilv, input string req);
        int L;
        L = len_of(code);
        launch(s, code, ilv);
        for (int k = 0; k < L; k++) begin
            chk({req, " col"}, col_o, exp_col(s, code, ilv, k));
            chk({req, " valid"}, valid_o, 1);
            chk({req, " R7 last"}, last_o, (k == L - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk({req, " R7 drop"}, valid_o, 0);
    endtask

    task automatic test_reset();
        rst_n = 0; start_i = 0; stop_i = 0; start_col_i = 0; burst_len_i = 0; interleave_i = 0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", valid_o, 0);
        chk("R1 last in reset", last_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 valid after reset", valid_o, 0);
        chk("R1 last after reset", last_o, 0);
    endtask

    task automatic test_example();
        int seq[8] = '{2, 3, 0, 1, 6, 7, 4, 5};
        launch(8'h32, 3'd3, 1);
        for (int k = 0; k < 8; k++) begin
            chk("R5 example", col_o, 8'h30 + seq[k]);
            @(negedge clk);
        end
    endtask

    task automatic test_page();
        launch(250, 3'd7, 1);
        for (int k = 0; k < 260; k++) begin
            chk("R8 page col", col_o, (250 + k) % 256);
            chk("R8 page last", last_o, 0);
            @(negedge clk);
        end
        chk("R8 still valid", valid_o, 1);
        stop_i = 1;
        @(negedge clk);
        stop_i = 0;
        chk("R9 stop ends page", valid_o, 0);
    endtask

    task automatic test_stop_vs_start();
        launch(8'h10, 3'd3, 0);
        @(negedge clk);
        stop_i = 1; start_i = 1; start_col_i = 8'h21; burst_len_i = 3'd1; interleave_i = 0;
        @(negedge clk);
        stop_i = 0; start_i = 0;
        chk("R9 start wins valid", valid_o, 1);
        chk("R9 start wins col", col_o, 8'h21);
        @(negedge clk);
        chk("R9 second beat", col_o, 8'h20);
        chk("R9 last", last_o, 1);
        @(negedge clk);
        launch(8'h40, 3'd2, 0);
        stop_i = 1;
        @(negedge clk);
        stop_i = 0;
        chk("R9 stop fixed burst", valid_o, 0);
    endtask

    task automatic test_restart();
        launch(8'h42, 3'd3, 1);
        repeat (2) @(negedge clk);
        chk("R10 before restart", col_o, 8'h40);
        start_i = 1; start_col_i = 8'h95; burst_len_i = 3'd2; interleave_i = 0;
        @(negedge clk);
        start_i = 0;
        for (int k = 0; k < 4; k++) begin
            chk("R10 restart col", col_o, exp_col(8'h95, 3'd2, 0, k));
            chk("R10 restart last", last_o, (k == 3) ? 1 : 0);
            @(negedge clk);
        end
        chk("R10 restart end", valid_o, 0);
    endtask

    task automatic test_back_to_back();
        launch(8'h07, 3'd0, 0);
        chk("R7 len1 last", last_o, 1);
        start_i = 1; start_col_i = 8'h0c; burst_len_i = 3'd1; interleave_i = 1;
        @(negedge clk);
        start_i = 0;
        chk("R7 restart on last valid", valid_o, 1);
        chk("R7 restart on last col", col_o, 8'h0c);
        @(negedge clk);
        chk("R7 second burst col", col_o, 8'h0d);
        @(negedge clk);
        chk("R7 second burst end", valid_o, 0);
    endtask

    task automatic test_cfg_hold();
        launch(8'h1b, 3'd3, 0);
        burst_len_i = 3'd7; interleave_i = 1;
        for (int k = 0; k < 8; k++) begin
            chk("R11 cfg held col", col_o, exp_col(8'h1b, 3'd3, 0, k));
            @(negedge clk);
        end
        chk("R11 cfg held end", valid_o, 0);
    endtask

    initial begin
        test_reset();
        run_burst(8'h57, 3'd0, 0, "R3 len1");
        run_burst(8'h57, 3'd1, 0, "R4 len2 seq");
        run_burst(8'h57, 3'd1, 1, "R5 len2 ilv");
        run_burst(8'h66, 3'd2, 0, "R4 len4 seq");
        run_burst(8'h66, 3'd2, 1, "R5 len4 ilv");
        run_burst(8'hcd, 3'd3, 0, "R4 R6 len8 seq");
        run_burst(8'hcd, 3'd3, 1, "R5 R6 len8 ilv");
        run_burst(8'hff, 3'd3, 0, "R6 len8 top");
        run_burst(8'h3a, 3'd4, 1, "R3 code4");
        run_burst(8'h3b, 3'd5, 0, "R3 code5");
        run_burst(8'h3c, 3'd6, 1, "R3 code6");
        test_example();
        test_page();
        test_stop_vs_start();
        test_restart();
        test_back_to_back();
        test_cfg_hold();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule